// File: doc/BRIEF.md
# MDIO Management Master Controller

This block drives single management frames toward external PHY devices over a two-wire management link. Software programs it through a small 32-bit register bus. It writes the 16-bit address word and the 16-bit write word first. It then writes the command word, which carries the frame type, the opcode, the PHY port, the device or register number and a start bit. The block generates the management clock from the system clock, shifts the frame out most significant bit first, and releases the data line for the turnaround and data phases of a read.

When a frame ends, the start bit drops back to zero. That bit is the only busy indication software needs to poll. A read leaves the returned word in the read-data register. If the PHY failed to pull the second turnaround bit low, a sticky fail flag is set. Frames that need more than one transaction, such as an indirect write or read, are issued by software as separate commands, one after another.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, every register reads zero, the management clock is low and the data output enable is low.
- R2: The byte offsets are: 0x0 command, 0x4 address word, 0x8 write word, 0xC read word, 0x10 status. The address word and write word read back their low 16 bits. The command word reads back its low 14 bits: [4:0] device/register, [9:5] port, [11:10] opcode, [13:12] frame type. Writing the command word with bit 14 clear starts no frame.
- R3: A command write with bit 14 set, made while idle, starts a frame. Bit 14 reads 1 from the next clock. It reads 0 exactly 64×DIV clocks after the write edge.
- R4: During a frame, the management clock is low for DIV/2 system clocks and then high for DIV/2, for each of 64 bits, starting low at launch. It stays low while idle.
- R5: A frame's bits come out MSB first in this order: 32 ones, frame type [13:12] (0 for the long-address kind, 1 for the short kind), opcode [11:10], port, device/register.
- R6: A frame whose opcode bit 1 is 0 is a write. For a write, the enable stays high for all 64 bits, and the turnaround is driven as 1 then 0, followed by 16 data bits. The data comes from the address word when both frame type and opcode are 0, and from the write word otherwise.
- R7: A frame whose opcode bit 1 is 1 is a read. For a read, the enable goes low from bit 46 (the first turnaround bit) to the end of the frame.
- R8: A read samples the data line on the 16 rising clock edges of bits 48 to 63, MSB first. The word is readable at 0xC [15:0] once bit 14 reads 0.
- R9: Status bit 0 is set when a read samples 1 in the second turnaround bit (bit 47). It is cleared when a new read starts. Write frames leave it unchanged.
- R10: A command write made while bit 14 reads 1 is ignored. Neither the stored fields nor the running frame change.
- R11: The data output changes only at launch and on falling edges of the management clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Sampled level of the data line |
| mdio_o | output | 1 | Level driven on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |

## Verification
The write edge that launches a frame sets the busy bit visible at the next sample. After that, everything is due at a fixed count of system clocks. The clock level at cycle t after launch is (t mod DIV) ≥ DIV/2, the bit index is t/DIV, and busy falls at t = 64×DIV. The reference model in the bench counts t from the launch edge and compares clock, enable and data output against its own bit list on every falling system-clock edge. The PHY model presents each response bit for a whole bit period. The busy bit is read at t = 0, at t = 64×DIV−1 and at t = 64×DIV. The read word and status are read only after busy has fallen.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int FRAME_BITS = 64;
  localparam int RELEASE_IDX = 46;
  localparam int TA2_IDX = 47;
  localparam int DATA_IDX = 48;
  localparam int IDX_W = $clog2(FRAME_BITS);

  localparam int W_CMD = 0;
  localparam int W_ADDR = 1;
  localparam int W_WDAT = 2;
  localparam int W_RDAT = 3;
  localparam int W_STAT = 4;
  localparam int START_BIT = 14;

  typedef struct packed {
    logic [1:0] st;
    logic [1:0] op;
    logic [4:0] prt;
    logic [4:0] dev;
  } cmd_t;

  function automatic logic f_is_read(logic [1:0] op);
    return op[1];
  endfunction

  function automatic logic f_data_from_addr(cmd_t c);
    return (c.st == 2'b00) && (c.op == 2'b00);
  endfunction

  function automatic logic [FRAME_BITS-1:0] f_build_frame(cmd_t c, logic [15:0] d);
    return {32'hFFFF_FFFF, c.st, c.op, c.prt, c.dev, 2'b10, d};
  endfunction
endpackage

// File: rtl/mm_clkgen.sv
module mm_clkgen #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic wrap;

  assign wrap = run && (cnt == LAST);
  assign rise_evt = wrap && !mdc;
  assign fall_evt = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/mm_shifter.sv
module mm_shifter
  import mm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  launch,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  is_read_in,
  input  logic                  rise_evt,
  input  logic                  fall_evt,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done,
  output logic [15:0]           rd_word,
  output logic                  ta_bad
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic [IDX_W-1:0]      idx;
  logic [FRAME_BITS-1:0] frm;
  logic                  rd_q;
  logic                  sample_ta;
  logic                  sample_dat;

  assign done = fall_evt && (idx == LAST_IDX);
  assign mdio_o = frm[FRAME_BITS-1];
  assign mdio_oe = busy && (!rd_q || (idx < IDX_W'(RELEASE_IDX)));
  assign sample_ta = rise_evt && rd_q && (idx == IDX_W'(TA2_IDX));
  assign sample_dat = rise_evt && rd_q && (idx >= IDX_W'(DATA_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx <= '0;
      frm <= '0;
      rd_q <= 1'b0;
      rd_word <= '0;
      ta_bad <= 1'b0;
    end else if (launch) begin
      busy <= 1'b1;
      idx <= '0;
      frm <= frame_in;
      rd_q <= is_read_in;
      rd_word <= '0;
      ta_bad <= 1'b0;
    end else if (busy) begin
      if (fall_evt) begin
        frm <= frm << 1;
        if (idx == LAST_IDX) busy <= 1'b0;
        else idx <= idx + IDX_W'(1);
      end
      if (sample_ta) ta_bad <= mdio_i;
      if (sample_dat) rd_word <= {rd_word[14:0], mdio_i};
    end
  end
endmodule

// File: rtl/mm_regs.sv
module mm_regs
  import mm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic                  busy,
  input  logic                  done,
  input  logic [15:0]           rd_word,
  input  logic                  ta_bad,
  output logic                  launch,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  is_read
);
  localparam int WW = ADDR_W - 2;

  cmd_t        cmd_q;
  cmd_t        cmd_new;
  logic [15:0] addr_q;
  logic [15:0] wdat_q;
  logic [15:0] rdat_q;
  logic        fail_q;
  logic [WW-1:0] word;
  logic        cmd_wr;
  logic        unused_bits;

  assign word = bus_addr[ADDR_W-1:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:15]};
  assign cmd_new = cmd_t'(bus_wdata[13:0]);
  assign cmd_wr = bus_we && (word == WW'(W_CMD)) && !busy;
  assign launch = cmd_wr && bus_wdata[START_BIT];
  assign is_read = f_is_read(cmd_new.op);
  assign frame = f_build_frame(cmd_new, f_data_from_addr(cmd_new) ? addr_q : wdat_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      fail_q <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= cmd_new;
      if (bus_we && (word == WW'(W_ADDR))) addr_q <= bus_wdata[15:0];
      if (bus_we && (word == WW'(W_WDAT))) wdat_q <= bus_wdata[15:0];
      if (launch && is_read) fail_q <= 1'b0;
      if (done && f_is_read(cmd_q.op)) begin
        rdat_q <= rd_word;
        fail_q <= ta_bad;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (word)
      WW'(W_CMD):  bus_rdata = {17'd0, busy, cmd_q};
      WW'(W_ADDR): bus_rdata = {16'd0, addr_q};
      WW'(W_WDAT): bus_rdata = {16'd0, wdat_q};
      WW'(W_RDAT): bus_rdata = {16'd0, rdat_q};
      WW'(W_STAT): bus_rdata = {31'd0, fail_q};
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mm_pkg::*;
#(
  parameter int unsigned DIV = 50,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic                  busy_w;
  logic                  launch_w;
  logic                  rise_w;
  logic                  fall_w;
  logic                  done_w;
  logic                  is_read_w;
  logic                  ta_bad_w;
  logic [15:0]           rd_word_w;
  logic [FRAME_BITS-1:0] frame_w;

  mm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy_w),
    .done(done_w), .rd_word(rd_word_w), .ta_bad(ta_bad_w),
    .launch(launch_w), .frame(frame_w), .is_read(is_read_w)
  );

  mm_clkgen #(.DIV(DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy_w), .mdc(mdc),
    .rise_evt(rise_w), .fall_evt(fall_w)
  );

  mm_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .launch(launch_w), .frame_in(frame_w),
    .is_read_in(is_read_w), .rise_evt(rise_w), .fall_evt(fall_w),
    .mdio_i(mdio_i), .busy(busy_w), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done_w), .rd_word(rd_word_w), .ta_bad(ta_bad_w)
  );
endmodule

// File: rtl/mm_checker.sv
module mm_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic launch,
  input logic rise_evt,
  input logic fall_evt,
  input logic done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  a_r4_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  a_r4_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({launch, rise_evt, fall_evt}));
  a_r3_launch_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);
  a_r3_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r10_no_launch_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);
  a_r7_drive_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);
  a_r11_data_on_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch && !fall_evt) |=> $stable(mdio_o));
endmodule

bind mdio_mgmt_master mm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .launch(launch_w),
  .rise_evt(rise_w), .fall_evt(fall_w), .done(done_w), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  localparam int DIV = 50;
  localparam int HALF = DIV / 2;
  localparam int FRAME_CYC = 64 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  bit   active = 0;
  int   t = 0;
  bit   exp_bits [64];
  bit   exp_read = 0;
  bit   rsp [18];
  int   wave_err = 0;
  int   first_bad_t = -1;
  int   mb;
  bit   mm;
  bit   moe;
  logic [15:0] addr_val = '0;
  logic [15:0] wd_val = '0;

  always #2 clk = ~clk;

  mdio_mgmt_master #(.DIV(DIV), .ADDR_W(5)) u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model: t counts system clocks since the launching edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (active) begin
        mb = t / DIV;
        mm = (t % DIV) >= HALF;
        moe = !exp_read || (mb < 46);
        if (mdc !== mm || mdio_oe !== moe || (moe && mdio_o !== exp_bits[mb])) begin
          if (wave_err == 0) first_bad_t = t;
          wave_err++;
        end
        mdio_i = (exp_read && mb >= 46) ? rsp[mb-46] : 1'b1;
        t++;
        if (t == FRAME_CYC) active = 0;
      end else begin
        if (mdc !== 1'b0 || mdio_oe !== 1'b0) wave_err++;
        mdio_i = 1'b1;
      end
    end
  end

  function automatic logic [31:0] cmd_word(logic [1:0] st, logic [1:0] op,
                                           logic [4:0] prt, logic [4:0] dev, logic go);
    logic [31:0] w;
    w = 32'd0;
    w[4:0] = dev;
    w[9:5] = prt;
    w[11:10] = op;
    w[13:12] = st;
    w[14] = go;
    return w;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input bit starts);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_we = 1'b1;
    @(posedge clk);
    if (starts) begin
      t = 0;
      active = 1;
    end
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic run_frame(input logic [1:0] st, input logic [1:0] op,
                           input logic [4:0] prt, input logic [4:0] dev,
                           input bit ta2, input logic [15:0] rdat,
                           input bit poke, input string tag);
    bit q[$];
    logic [15:0] dat;
    logic [31:0] v;
    int c;
    for (int i = 0; i < 32; i++) q.push_back(1'b1);
    for (int i = 1; i >= 0; i--) q.push_back(st[i]);
    for (int i = 1; i >= 0; i--) q.push_back(op[i]);
    for (int i = 4; i >= 0; i--) q.push_back(prt[i]);
    for (int i = 4; i >= 0; i--) q.push_back(dev[i]);
    q.push_back(1'b1);
    q.push_back(1'b0);
    dat = (st == 2'b00 && op == 2'b00) ? addr_val : wd_val;
    for (int i = 15; i >= 0; i--) q.push_back(dat[i]);
    for (int i = 0; i < 64; i++) exp_bits[i] = q[i];
    exp_read = op[1];
    rsp[0] = 1'b1;
    rsp[1] = ta2;
    for (int i = 0; i < 16; i++) rsp[2+i] = rdat[15-i];
    wave_err = 0;
    first_bad_t = -1;
    wr(5'h00, cmd_word(st, op, prt, dev, 1'b1), 1);
    c = 0;
    rd(5'h00, v);
    chk(v[14] == 1'b1, {"R3 busy at launch ", tag}, v, 32'h4000);
    if (poke) begin
      repeat (100) @(negedge clk);
      wr(5'h00, cmd_word(2'b00, 2'b11, 5'h1F, 5'h1F, 1'b1), 0);
      c = 102;
    end
    repeat (FRAME_CYC - 1 - c) @(negedge clk);
    rd(5'h00, v);
    chk(v[14] == 1'b1, {"R3 busy before end ", tag}, v, 32'h4000);
    @(negedge clk);
    rd(5'h00, v);
    chk(v == cmd_word(st, op, prt, dev, 1'b0), {"R3 R10 command after end ", tag},
        v, cmd_word(st, op, prt, dev, 1'b0));
    @(negedge clk);
    chk(wave_err == 0, {"R4 R5 R6 R7 R11 waveform ", tag}, first_bad_t, 0);
    if (exp_read) begin
      rd(5'h0C, v);
      chk(v == {16'd0, rdat}, {"R8 read word ", tag}, v, {16'd0, rdat});
      rd(5'h10, v);
      chk(v == {31'd0, ta2}, {"R9 status ", tag}, v, {31'd0, ta2});
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a <= 16; a += 4) begin
      rd(a[4:0], v);
      chk(v == 32'd0, "R1 register after reset", v, 32'd0);
    end
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins after reset", {mdc, mdio_oe}, 0);

    // R2 readback
    wr(5'h04, 32'hABCD_1234, 0);
    addr_val = 16'h1234;
    rd(5'h04, v);
    chk(v == 32'h0000_1234, "R2 address word", v, 32'h0000_1234);
    wr(5'h08, 32'hFFFF_BEEF, 0);
    wd_val = 16'hBEEF;
    rd(5'h08, v);
    chk(v == 32'h0000_BEEF, "R2 write word", v, 32'h0000_BEEF);
    wave_err = 0;
    wr(5'h00, cmd_word(2'b01, 2'b10, 5'h05, 5'h03, 1'b0), 0);
    repeat (3 * DIV) @(negedge clk);
    rd(5'h00, v);
    chk(v == cmd_word(2'b01, 2'b10, 5'h05, 5'h03, 1'b0), "R2 command fields",
        v, cmd_word(2'b01, 2'b10, 5'h05, 5'h03, 1'b0));
    chk(wave_err == 0, "R2 R4 no frame without start", wave_err, 0);

    // short-kind write, data from write word
    run_frame(2'b01, 2'b01, 5'h11, 5'h0A, 1'b0, 16'h0000, 0, "short write");
    // long-kind address frame, data from address word
    run_frame(2'b00, 2'b00, 5'h03, 5'h1E, 1'b0, 16'h0000, 0, "long address");
    // long-kind write, data from write word
    wr(5'h08, 32'h0000_5A3C, 0);
    wd_val = 16'h5A3C;
    run_frame(2'b00, 2'b01, 5'h1C, 5'h01, 1'b0, 16'h0000, 0, "long write");
    // short-kind read, good turnaround, with a write poked while busy
    run_frame(2'b01, 2'b10, 5'h09, 5'h15, 1'b0, 16'hC3A5, 1, "short read R10");
    // long-kind read, PHY leaves turnaround high
    run_frame(2'b00, 2'b11, 5'h02, 5'h07, 1'b1, 16'h6E91, 0, "long read failed");
    // write leaves the fail flag
    run_frame(2'b01, 2'b01, 5'h00, 5'h1F, 1'b0, 16'h0000, 0, "short write after fail");
    rd(5'h10, v);
    chk(v == 32'd1, "R9 write keeps fail flag", v, 32'd1);
    // long-kind read with increment clears the flag
    run_frame(2'b00, 2'b10, 5'h1F, 5'h00, 1'b0, 16'h0F0F, 0, "long read inc");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule